// File: doc/BRIEF.md
# Variable-length instruction field decoder

This block receives a machine instruction as a stream of bytes, one byte for each cycle in which `in_valid` is high, and splits it into its fields. The instruction set is byte-oriented with variable-length encoding, and the block decodes it with 32-bit addressing. Each instruction may begin with legacy prefix bytes and one register-extension byte. These are followed by a one-byte opcode, or by the escape byte 0x0F and a second opcode byte. A built-in table decides, for each accepted opcode, whether an operand-form byte follows and how wide the immediate is.

The operand-form byte decides whether a scaled-index byte follows and how many displacement bytes follow. The length of the instruction therefore changes from one instruction to the next. When the last byte has been taken, the block pulses `done` and holds all decoded fields until the next instruction starts. The decoded fields are the prefix flags, the extension bits, the opcode, the three operand-form fields, the scaled-index fields, and the sign-extended displacement and immediate. An opcode outside the table ends the instruction early with `invalid` set.

Top module: `instr_field_decoder`

## Requirements
- R1: After reset `done` and `invalid` are low and `ins_len` is 0; the first byte accepted after reset starts a new instruction.
- R2: Prefix bytes are consumed before the opcode and set bits of `pfx_flags`: 0xF0 sets bit 0, 0xF2 bit 1, 0xF3 bit 2, any of 0x26, 0x2E, 0x36, 0x3E, 0x64, 0x65 sets bit 3, 0x66 bit 4, 0x67 bit 5.
- R3: At most MAX_PFX prefix and extension bytes are accepted per instruction (default 4); one more such byte ends the instruction with `done` and `invalid` high, and `ins_len` counts that byte.
- R4: A byte of the form 0100WRXB before the opcode sets `ext_seen` and reports WRXB on `ext_wrxb` (W in bit 3), so 0x48 gives 4'b1000.
- R5: Byte 0x0F selects a two-byte opcode (`two_byte` high, `opcode` holds the second byte). An opcode outside the supported table ends the instruction on that byte with `invalid` high. Supported opcodes include 0x00-0x3F with low bits 0-5, 0x50-0x5F, 0x70-0x7F, 0x89, 0x8B, 0x81, 0x83, 0xB0-0xBF, 0xC7, and, after the escape, 0x80-0x8F, 0xAF and 0xB6.
- R6: The operand-form byte is split into `amode` = bits 7:6, `regf` = bits 5:3 and `rmf` = bits 2:0.
- R7: A scaled-index byte follows the operand-form byte when `amode` is not 3 and `rmf` is 4. Its bits 7:6 give `idx_scale` = 1, 2, 4 or 8, bits 5:3 give `idx_index`, and bits 2:0 give `idx_base`.
- R8: Displacement length is 1 byte for `amode` 1 and 4 bytes for `amode` 2. It is also 4 bytes for `amode` 0 when `rmf` is 5, or when a scaled-index byte with base 5 is present; otherwise it is 0. Bytes are little-endian and `disp_val` is sign-extended.
- R9: The immediate follows the displacement. Its length is 0, 1, or full: full is 4 bytes, or 2 bytes when 0x66 was seen. It is little-endian and `imm_val` is sign-extended.
- R10: `done` is high for exactly the cycle after the last byte is accepted, and `ins_len` gives the total byte count including prefixes. Cycles with `in_valid` low change nothing.
- R11: The stream 0x89 0x45 0xFC decodes as opcode 0x89, amode 1, regf 0, rmf 5, displacement 0xFFFFFFFC (-4), length 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | `in_byte` carries an instruction byte this cycle |
| in_byte | input | 8 | Instruction byte |
| done | output | 1 | One-cycle pulse: instruction complete, fields valid |
| invalid | output | 1 | Instruction ended on an unsupported opcode or too many prefixes |
| pfx_flags | output | 6 | Prefix flags (R2) |
| ext_seen | output | 1 | Extension byte present |
| ext_wrxb | output | 4 | Extension bits W, R, X, B |
| two_byte | output | 1 | Escape byte 0x0F seen |
| opcode | output | 8 | Opcode byte (second byte if escaped) |
| has_form | output | 1 | Operand-form byte present |
| amode | output | 2 | Addressing mode field |
| regf | output | 3 | Register / opcode-extension field |
| rmf | output | 3 | Register-or-memory field |
| has_idx | output | 1 | Scaled-index byte present |
| idx_scale | output | 4 | Scale multiplier 1, 2, 4 or 8 |
| idx_index | output | 3 | Index register number |
| idx_base | output | 3 | Base register number |
| disp_bytes | output | 3 | Displacement length in bytes |
| disp_val | output | DW | Sign-extended displacement |
| imm_bytes | output | 3 | Immediate length in bytes |
| imm_val | output | DW | Sign-extended immediate |
| ins_len | output | LEN_W | Total instruction length in bytes |

## Verification
A wrong state transition consumes the wrong number of bytes. The `done` pulse then arrives early or late, `ins_len` disagrees at once, and every later instruction in the stream is framed wrongly. A wrong byte position or length register shows up as a scrambled or wrongly extended `disp_val` or `imm_val` at that same `done` pulse. A stale field left over from the previous instruction appears in the flags or the scaled-index outputs of the next one. Random streams mix prefixes, extension bytes, every addressing mode and idle gaps, so each of these faults is caught within a few instructions.

// File: rtl/ifd_pkg.sv
package ifd_pkg;

   typedef enum logic [1:0] {
      IK_NONE = 2'd0,
      IK_BYTE = 2'd1,
      IK_FULL = 2'd2
   } imm_kind_e;

   typedef struct packed {
      logic      ok;
      logic      form;
      imm_kind_e ik;
   } opc_info_t;

   typedef enum logic [2:0] {
      S_PFX  = 3'd0,
      S_ESC  = 3'd1,
      S_FORM = 3'd2,
      S_IDX  = 3'd3,
      S_DISP = 3'd4,
      S_IMM  = 3'd5
   } dec_state_e;

   localparam int FLAG_W = 6;

   // flag mask for a legacy prefix byte, zero when the byte is not a prefix
   function automatic logic [FLAG_W-1:0] legacy_mask(input logic [7:0] b);
      logic [FLAG_W-1:0] m;
      m = '0;
      case (b)
         8'hF0: m[0] = 1'b1;
         8'hF2: m[1] = 1'b1;
         8'hF3: m[2] = 1'b1;
         8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65: m[3] = 1'b1;
         8'h66: m[4] = 1'b1;
         8'h67: m[5] = 1'b1;
         default: m = '0;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/ifd_opc_table.sv
module ifd_opc_table
   import ifd_pkg::*;
(
   input  logic       esc,
   input  logic [7:0] op,
   output opc_info_t  info
);

   always_comb begin
      info = '{ok: 1'b0, form: 1'b0, ik: IK_NONE};
      if (!esc) begin
         if (op[7:6] == 2'b00 && op[2:0] <= 3'd5) begin
            info.ok = 1'b1;
            if (!op[2]) info.form = 1'b1;
            else        info.ik   = op[0] ? IK_FULL : IK_BYTE;
         end else if (op[7:4] == 4'h5) begin
            info.ok = 1'b1;
         end else if (op[7:4] == 4'h7) begin
            info.ok = 1'b1;
            info.ik = IK_BYTE;
         end else if (op[7:4] == 4'h9 && !op[3]) begin
            info.ok = 1'b1;
         end else if (op[7:4] == 4'hB) begin
            info.ok = 1'b1;
            info.ik = op[3] ? IK_FULL : IK_BYTE;
         end else begin
            case (op)
               8'h68, 8'hE8, 8'hE9: begin info.ok = 1'b1; info.ik = IK_FULL; end
               8'h6A, 8'hEB:        begin info.ok = 1'b1; info.ik = IK_BYTE; end
               8'h69, 8'h81, 8'hC7: begin info.ok = 1'b1; info.form = 1'b1; info.ik = IK_FULL; end
               8'h6B, 8'h80, 8'h83, 8'hC6: begin info.ok = 1'b1; info.form = 1'b1; info.ik = IK_BYTE; end
               8'h84, 8'h85, 8'h86, 8'h87, 8'h88, 8'h89, 8'h8A, 8'h8B,
               8'h8D, 8'h8F, 8'hFF: begin info.ok = 1'b1; info.form = 1'b1; end
               8'hC3:               info.ok = 1'b1;
               default:             info.ok = 1'b0;
            endcase
         end
      end else begin
         if (op[7:4] == 4'h8) begin
            info.ok = 1'b1;
            info.ik = IK_FULL;
         end else begin
            case (op)
               8'h1F, 8'hAF, 8'hB6, 8'hB7, 8'hBE, 8'hBF: begin info.ok = 1'b1; info.form = 1'b1; end
               default: info.ok = 1'b0;
            endcase
         end
      end
   end

endmodule

// File: rtl/ifd_layout.sv
module ifd_layout (
   input  logic [1:0] amode,
   input  logic [2:0] sel,
   output logic       need_idx,
   output logic [2:0] dlen
);

   localparam logic [2:0] SEL_IDX   = 3'd4;
   localparam logic [2:0] SEL_NOBASE = 3'd5;

   always_comb begin
      need_idx = (amode != 2'b11) && (sel == SEL_IDX);
      case (amode)
         2'b01:   dlen = 3'd1;
         2'b10:   dlen = 3'd4;
         2'b00:   dlen = (sel == SEL_NOBASE) ? 3'd4 : 3'd0;
         default: dlen = 3'd0;
      endcase
   end

endmodule

// File: rtl/ifd_sext.sv
module ifd_sext #(
   parameter int OUT_W  = 32,
   parameter bit SIGNED = 1'b1
) (
   input  logic [31:0]      raw,
   input  logic [2:0]       nbytes,
   output logic [OUT_W-1:0] val
);

   if (OUT_W < 32) begin : g_bad_width
      $fatal(1, "ifd_sext: OUT_W must be at least 32");
   end

   if (SIGNED) begin : g_signed
      always_comb begin
         case (nbytes)
            3'd1:    val = OUT_W'(signed'(raw[7:0]));
            3'd2:    val = OUT_W'(signed'(raw[15:0]));
            3'd4:    val = OUT_W'(signed'(raw));
            default: val = '0;
         endcase
      end
   end else begin : g_unsigned
      always_comb begin
         case (nbytes)
            3'd1:    val = OUT_W'(raw[7:0]);
            3'd2:    val = OUT_W'(raw[15:0]);
            3'd4:    val = OUT_W'(raw);
            default: val = '0;
         endcase
      end
   end

endmodule

// File: rtl/instr_field_decoder.sv
module instr_field_decoder
   import ifd_pkg::*;
#(
   parameter int MAX_PFX = 4,
   parameter int DW      = 32,
   localparam int MAX_LEN = MAX_PFX + 12,
   localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_byte,
   output logic              done,
   output logic              invalid,
   output logic [5:0]        pfx_flags,
   output logic              ext_seen,
   output logic [3:0]        ext_wrxb,
   output logic              two_byte,
   output logic [7:0]        opcode,
   output logic              has_form,
   output logic [1:0]        amode,
   output logic [2:0]        regf,
   output logic [2:0]        rmf,
   output logic              has_idx,
   output logic [3:0]        idx_scale,
   output logic [2:0]        idx_index,
   output logic [2:0]        idx_base,
   output logic [2:0]        disp_bytes,
   output logic [DW-1:0]     disp_val,
   output logic [2:0]        imm_bytes,
   output logic [DW-1:0]     imm_val,
   output logic [LEN_W-1:0]  ins_len
);

   localparam int PC_W = $clog2(MAX_PFX + 1);

   if (MAX_PFX < 1 || MAX_PFX > 14) begin : g_bad_pfx
      $fatal(1, "instr_field_decoder: MAX_PFX out of range 1..14");
   end
   if (DW < 32) begin : g_bad_dw
      $fatal(1, "instr_field_decoder: DW must be at least 32");
   end

   dec_state_e        state_q, state_d;
   logic              fresh_q, fresh_d;
   logic              done_q, done_d;
   logic              inv_q, inv_d;
   logic [LEN_W-1:0]  cnt_q, cnt_d;
   logic [PC_W-1:0]   npfx_q, npfx_d;
   logic [5:0]        flags_q, flags_d;
   logic              exts_q, exts_d;
   logic [3:0]        ext_q, ext_d;
   logic              esc_q, esc_d;
   logic [7:0]        op_q, op_d;
   logic              form_q, form_d;
   logic [7:0]        mrm_q, mrm_d;
   logic              idxs_q, idxs_d;
   logic [7:0]        sib_q, sib_d;
   logic [2:0]        dlen_q, dlen_d;
   logic [2:0]        ilen_q, ilen_d;
   logic [31:0]       draw_q, draw_d;
   logic [31:0]       iraw_q, iraw_d;
   logic [1:0]        bpos_q, bpos_d;

   logic [5:0]        pmask;
   opc_info_t         info;
   logic [1:0]        lay_amode;
   logic              lay_need_idx;
   logic [2:0]        lay_dlen;
   logic              take_opc, after_addr, finish;

   assign pmask     = legacy_mask(in_byte);
   assign lay_amode = (state_q == S_FORM) ? in_byte[7:6] : mrm_q[7:6];

   ifd_opc_table u_table (
      .esc  (state_q == S_ESC),
      .op   (in_byte),
      .info (info)
   );

   ifd_layout u_layout (
      .amode    (lay_amode),
      .sel      (in_byte[2:0]),
      .need_idx (lay_need_idx),
      .dlen     (lay_dlen)
   );

   always_comb begin
      state_d = state_q;  fresh_d = fresh_q;  done_d = 1'b0;   inv_d = inv_q;
      cnt_d   = cnt_q;    npfx_d  = npfx_q;   flags_d = flags_q;
      exts_d  = exts_q;   ext_d   = ext_q;    esc_d  = esc_q;  op_d = op_q;
      form_d  = form_q;   mrm_d   = mrm_q;    idxs_d = idxs_q; sib_d = sib_q;
      dlen_d  = dlen_q;   ilen_d  = ilen_q;   draw_d = draw_q; iraw_d = iraw_q;
      bpos_d  = bpos_q;
      take_opc = 1'b0;  after_addr = 1'b0;  finish = 1'b0;

      if (in_valid) begin
         if (fresh_q) begin
            fresh_d = 1'b0; inv_d = 1'b0; cnt_d = '0; npfx_d = '0; flags_d = '0;
            exts_d = 1'b0; ext_d = '0; esc_d = 1'b0; op_d = '0; form_d = 1'b0;
            mrm_d = '0; idxs_d = 1'b0; sib_d = '0; dlen_d = '0; ilen_d = '0;
            draw_d = '0; iraw_d = '0; bpos_d = '0;
         end
         cnt_d = cnt_d + LEN_W'(1);

         case (state_q)
            S_PFX: begin
               if (pmask != '0 || in_byte[7:4] == 4'h4) begin
                  if (npfx_d == PC_W'(MAX_PFX)) begin
                     inv_d  = 1'b1;
                     finish = 1'b1;
                  end else begin
                     npfx_d  = npfx_d + PC_W'(1);
                     flags_d = flags_d | pmask;
                     if (in_byte[7:4] == 4'h4) begin
                        exts_d = 1'b1;
                        ext_d  = in_byte[3:0];
                     end
                  end
               end else if (in_byte == 8'h0F) begin
                  esc_d   = 1'b1;
                  state_d = S_ESC;
               end else begin
                  take_opc = 1'b1;
               end
            end
            S_ESC: take_opc = 1'b1;
            S_FORM: begin
               mrm_d = in_byte;
               if (lay_need_idx) begin
                  idxs_d  = 1'b1;
                  state_d = S_IDX;
               end else begin
                  dlen_d     = lay_dlen;
                  after_addr = 1'b1;
               end
            end
            S_IDX: begin
               sib_d      = in_byte;
               dlen_d     = lay_dlen;
               after_addr = 1'b1;
            end
            S_DISP: begin
               draw_d[{bpos_q, 3'b000} +: 8] = in_byte;
               if ({1'b0, bpos_q} == dlen_q - 3'd1) begin
                  bpos_d = '0;
                  if (ilen_q != 3'd0) state_d = S_IMM;
                  else                finish  = 1'b1;
               end else begin
                  bpos_d = bpos_q + 2'd1;
               end
            end
            S_IMM: begin
               iraw_d[{bpos_q, 3'b000} +: 8] = in_byte;
               if ({1'b0, bpos_q} == ilen_q - 3'd1) begin
                  bpos_d = '0;
                  finish = 1'b1;
               end else begin
                  bpos_d = bpos_q + 2'd1;
               end
            end
            default: begin
               inv_d  = 1'b1;
               finish = 1'b1;
            end
         endcase

         if (take_opc) begin
            op_d = in_byte;
            if (!info.ok) begin
               inv_d  = 1'b1;
               finish = 1'b1;
            end else begin
               form_d = info.form;
               case (info.ik)
                  IK_BYTE: ilen_d = 3'd1;
                  IK_FULL: ilen_d = flags_d[4] ? 3'd2 : 3'd4;
                  default: ilen_d = 3'd0;
               endcase
               if (info.form)           state_d = S_FORM;
               else if (ilen_d != 3'd0) state_d = S_IMM;
               else                     finish  = 1'b1;
            end
         end

         if (after_addr) begin
            if (dlen_d != 3'd0)      state_d = S_DISP;
            else if (ilen_d != 3'd0) state_d = S_IMM;
            else                     finish  = 1'b1;
         end

         if (finish) begin
            done_d  = 1'b1;
            fresh_d = 1'b1;
            state_d = S_PFX;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_PFX;  fresh_q <= 1'b1;  done_q <= 1'b0;  inv_q <= 1'b0;
         cnt_q   <= '0;     npfx_q  <= '0;    flags_q <= '0;
         exts_q  <= 1'b0;   ext_q   <= '0;    esc_q  <= 1'b0;  op_q <= '0;
         form_q  <= 1'b0;   mrm_q   <= '0;    idxs_q <= 1'b0;  sib_q <= '0;
         dlen_q  <= '0;     ilen_q  <= '0;    draw_q <= '0;    iraw_q <= '0;
         bpos_q  <= '0;
      end else begin
         state_q <= state_d;  fresh_q <= fresh_d;  done_q <= done_d;  inv_q <= inv_d;
         cnt_q   <= cnt_d;    npfx_q  <= npfx_d;   flags_q <= flags_d;
         exts_q  <= exts_d;   ext_q   <= ext_d;    esc_q  <= esc_d;   op_q <= op_d;
         form_q  <= form_d;   mrm_q   <= mrm_d;    idxs_q <= idxs_d;  sib_q <= sib_d;
         dlen_q  <= dlen_d;   ilen_q  <= ilen_d;   draw_q <= draw_d;  iraw_q <= iraw_d;
         bpos_q  <= bpos_d;
      end
   end

   ifd_sext #(.OUT_W(DW), .SIGNED(1'b1)) u_disp_ext (
      .raw    (draw_q),
      .nbytes (dlen_q),
      .val    (disp_val)
   );

   ifd_sext #(.OUT_W(DW), .SIGNED(1'b1)) u_imm_ext (
      .raw    (iraw_q),
      .nbytes (ilen_q),
      .val    (imm_val)
   );

   assign done       = done_q;
   assign invalid    = inv_q;
   assign pfx_flags  = flags_q;
   assign ext_seen   = exts_q;
   assign ext_wrxb   = ext_q;
   assign two_byte   = esc_q;
   assign opcode     = op_q;
   assign has_form   = form_q;
   assign amode      = mrm_q[7:6];
   assign regf       = mrm_q[5:3];
   assign rmf        = mrm_q[2:0];
   assign has_idx    = idxs_q;
   assign idx_scale  = 4'b0001 << sib_q[7:6];
   assign idx_index  = sib_q[5:3];
   assign idx_base   = sib_q[2:0];
   assign disp_bytes = dlen_q;
   assign imm_bytes  = ilen_q;
   assign ins_len    = cnt_q;

endmodule

// File: rtl/ifd_checker.sv
module ifd_checker #(
   parameter int LEN_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             done,
   input logic             invalid,
   input logic [5:0]       pfx_flags,
   input logic             two_byte,
   input logic             has_form,
   input logic [1:0]       amode,
   input logic [2:0]       rmf,
   input logic             has_idx,
   input logic [2:0]       disp_bytes,
   input logic [2:0]       imm_bytes,
   input logic [LEN_W-1:0] ins_len
);

   // R10: a completion pulse only follows a cycle that carried a byte
   a_r10_done_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !done);

   // R7: scaled-index byte only with a memory form selecting it
   a_r7_idx_only_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !invalid && has_idx) |-> (has_form && amode != 2'b11 && rmf == 3'd4));

   // R8: mode 1 always carries one displacement byte
   a_r8_short_disp: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !invalid && has_form && amode == 2'b01) |-> (disp_bytes == 3'd1));

   // R8: register form has neither displacement nor scaled-index byte
   a_r8_reg_form_bare: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !invalid && has_form && amode == 2'b11) |-> (disp_bytes == 3'd0 && !has_idx));

   // R9: a two-byte immediate needs the operand-size prefix
   a_r9_half_imm_needs_prefix: assert property (@(posedge clk) disable iff (!rst_n)
      (done && imm_bytes == 3'd2) |-> pfx_flags[4]);

   // R10: reported length covers every field that was reported present
   a_r10_len_covers_fields: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !invalid) |-> (32'(ins_len) >= 32'd1 + 32'(two_byte) + 32'(has_form)
                              + 32'(has_idx) + 32'(disp_bytes) + 32'(imm_bytes)));

endmodule

bind instr_field_decoder ifd_checker #(.LEN_W(LEN_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .done       (done),
   .invalid    (invalid),
   .pfx_flags  (pfx_flags),
   .two_byte   (two_byte),
   .has_form   (has_form),
   .amode      (amode),
   .rmf        (rmf),
   .has_idx    (has_idx),
   .disp_bytes (disp_bytes),
   .imm_bytes  (imm_bytes),
   .ins_len    (ins_len)
);

// File: tb/instr_field_decoder_test.sv
`timescale 1ns/1ps
module instr_field_decoder_test;

   localparam int MAX_PFX = 4;
   localparam int DW      = 32;
   localparam int LEN_W   = $clog2(MAX_PFX + 12 + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [7:0]       in_byte = 8'h00;
   logic             done, invalid, ext_seen, two_byte, has_form, has_idx;
   logic [5:0]       pfx_flags;
   logic [3:0]       ext_wrxb, idx_scale;
   logic [7:0]       opcode;
   logic [1:0]       amode;
   logic [2:0]       regf, rmf, idx_index, idx_base, disp_bytes, imm_bytes;
   logic [DW-1:0]    disp_val, imm_val;
   logic [LEN_W-1:0] ins_len;

   always #2.5 clk = ~clk;

   instr_field_decoder #(.MAX_PFX(MAX_PFX), .DW(DW)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .done(done), .invalid(invalid), .pfx_flags(pfx_flags), .ext_seen(ext_seen),
      .ext_wrxb(ext_wrxb), .two_byte(two_byte), .opcode(opcode), .has_form(has_form),
      .amode(amode), .regf(regf), .rmf(rmf), .has_idx(has_idx), .idx_scale(idx_scale),
      .idx_index(idx_index), .idx_base(idx_base), .disp_bytes(disp_bytes),
      .disp_val(disp_val), .imm_bytes(imm_bytes), .imm_val(imm_val), .ins_len(ins_len)
   );

   int nchk = 0;
   int nerr = 0;

   logic [7:0] pkt [0:31];
   int         plen;

   logic        e_inv, e_exts, e_two, e_form, e_idx;
   logic [5:0]  e_flags;
   logic [3:0]  e_ext;
   logic [7:0]  e_op, e_mrm, e_sib;
   int          e_dlen, e_ilen;
   logic [31:0] e_dval, e_ival;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [5:0] pbit(input logic [7:0] b);
      case (b)
         8'hF0: return 6'b000001;
         8'hF2: return 6'b000010;
         8'hF3: return 6'b000100;
         8'h66: return 6'b010000;
         8'h67: return 6'b100000;
         default: return 6'b001000;
      endcase
   endfunction

   function automatic logic [31:0] sx(input logic [31:0] raw, input int n);
      if (n == 1) return {{24{raw[7]}}, raw[7:0]};
      if (n == 2) return {{16{raw[15]}}, raw[15:0]};
      if (n == 4) return raw;
      return 32'h0;
   endfunction

   function automatic int disp_len(input logic [1:0] m, input logic [2:0] s);
      if (m == 2'd1) return 1;
      if (m == 2'd2) return 4;
      if (m == 2'd0 && s == 3'd5) return 4;
      return 0;
   endfunction

   task automatic clear_exp();
      plen = 0; e_inv = 0; e_exts = 0; e_two = 0; e_form = 0; e_idx = 0;
      e_flags = '0; e_ext = '0; e_op = '0; e_mrm = '0; e_sib = '0;
      e_dlen = 0; e_ilen = 0; e_dval = '0; e_ival = '0;
   endtask

   task automatic push(input logic [7:0] b);
      pkt[plen] = b;
      plen++;
   endtask

   task automatic add_field(input logic [31:0] raw, input int n);
      for (int i = 0; i < n; i++) push(raw[8*i +: 8]);
   endtask

   // feed the packet, then compare outputs on the cycle after the last byte
   task automatic run(input string tag, input bit gaps);
      bit early = 0;
      for (int i = 0; i < plen; i++) begin
         if (gaps && ($urandom % 4 == 0)) begin
            @(negedge clk);
            if (done) early = 1;
            in_valid = 1'b0;
            in_byte  = $urandom;
         end
         @(negedge clk);
         if (done) early = 1;
         in_valid = 1'b1;
         in_byte  = pkt[i];
      end
      @(negedge clk);
      in_valid = 1'b0;
      check({tag, " R10"}, "early done", early, 0);
      check({tag, " R10"}, "done pulse", done, 1);
      check({tag, " R10"}, "length", ins_len, plen);
      check({tag, " R5"}, "invalid", invalid, e_inv);
      if (!e_inv) begin
         check({tag, " R2"}, "prefix flags", pfx_flags, e_flags);
         check({tag, " R4"}, "ext seen", ext_seen, e_exts);
         if (e_exts) check({tag, " R4"}, "ext bits", ext_wrxb, e_ext);
         check({tag, " R5"}, "escape", two_byte, e_two);
         check({tag, " R5"}, "opcode", opcode, e_op);
         check({tag, " R6"}, "has form", has_form, e_form);
         if (e_form) begin
            check({tag, " R6"}, "amode", amode, e_mrm[7:6]);
            check({tag, " R6"}, "regf", regf, e_mrm[5:3]);
            check({tag, " R6"}, "rmf", rmf, e_mrm[2:0]);
         end
         check({tag, " R7"}, "has idx", has_idx, e_idx);
         if (e_idx) begin
            check({tag, " R7"}, "scale", idx_scale, 4'd1 << e_sib[7:6]);
            check({tag, " R7"}, "index", idx_index, e_sib[5:3]);
            check({tag, " R7"}, "base", idx_base, e_sib[2:0]);
         end
         check({tag, " R8"}, "disp len", disp_bytes, e_dlen);
         check({tag, " R8"}, "disp val", disp_val, e_dval);
         check({tag, " R9"}, "imm len", imm_bytes, e_ilen);
         check({tag, " R9"}, "imm val", imm_val, e_ival);
      end
      @(negedge clk);
      check({tag, " R10"}, "done single cycle", done, 0);
   endtask

   logic [7:0] ptab [0:10] = '{8'hF0, 8'hF2, 8'hF3, 8'h2E, 8'h36, 8'h3E,
                               8'h26, 8'h64, 8'h65, 8'h66, 8'h67};
   bit         oesc [0:11] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1};
   logic [7:0] oval [0:11] = '{8'h01, 8'h05, 8'h04, 8'h81, 8'h83, 8'h8B,
                               8'hB8, 8'h6A, 8'h50, 8'hC7, 8'h84, 8'hAF};
   bit         ofrm [0:11] = '{1, 0, 0, 1, 1, 1, 0, 0, 0, 1, 0, 1};
   int         oik  [0:11] = '{0, 2, 1, 2, 1, 0, 2, 1, 0, 2, 2, 0};

   task automatic gen_random();
      int          np, k;
      logic [7:0]  b, m, s;
      logic [31:0] raw;
      clear_exp();
      np = $urandom % 3;
      for (int i = 0; i < np; i++) begin
         b = ptab[$urandom % 11];
         push(b);
         e_flags |= pbit(b);
      end
      if ($urandom % 2) begin
         e_exts = 1;
         e_ext  = $urandom;
         push({4'h4, e_ext});
      end
      k = $urandom % 12;
      if (oesc[k]) begin e_two = 1; push(8'h0F); end
      e_op = oval[k];
      push(e_op);
      if (ofrm[k]) begin
         e_form = 1;
         m = $urandom;
         e_mrm = m;
         push(m);
         if (m[7:6] != 2'd3 && m[2:0] == 3'd4) begin
            s = $urandom;
            e_idx = 1;
            e_sib = s;
            push(s);
            e_dlen = disp_len(m[7:6], s[2:0]);
         end else begin
            e_dlen = (m[7:6] == 2'd3) ? 0 : disp_len(m[7:6], m[2:0]);
         end
         raw = $urandom;
         add_field(raw, e_dlen);
         e_dval = sx(raw, e_dlen);
      end
      e_ilen = (oik[k] == 1) ? 1 : (oik[k] == 2) ? (e_flags[4] ? 2 : 4) : 0;
      raw = $urandom;
      add_field(raw, e_ilen);
      e_ival = sx(raw, e_ilen);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1", "done after reset", done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "done idle", done, 0);
      check("R1", "invalid idle", invalid, 0);
      check("R1", "length idle", ins_len, 0);

      // R11 worked example, also the first instruction after reset (R1)
      clear_exp(); push(8'h89); push(8'h45); push(8'hFC);
      e_op = 8'h89; e_form = 1; e_mrm = 8'h45; e_dlen = 1; e_dval = 32'hFFFF_FFFC;
      run("R11 R1", 0);

      // R4 extension byte 0x48 before a register form
      clear_exp(); push(8'h48); push(8'h89); push(8'hC8);
      e_exts = 1; e_ext = 4'b1000; e_op = 8'h89; e_form = 1; e_mrm = 8'hC8;
      run("R4 w-set", 0);

      // R9 operand-size prefix shrinks a full immediate to two bytes
      clear_exp(); push(8'h66); push(8'hC7); push(8'h00); push(8'h34); push(8'h92);
      e_flags = 6'b010000; e_op = 8'hC7; e_form = 1; e_mrm = 8'h00;
      e_ilen = 2; e_ival = 32'hFFFF_9234;
      run("R9 half imm", 0);

      // R8 index byte with base 5 in mode 0 brings a four-byte displacement
      clear_exp(); push(8'h8B); push(8'h04); push(8'hE5); add_field(32'h1234_5678, 4);
      e_op = 8'h8B; e_form = 1; e_mrm = 8'h04; e_idx = 1; e_sib = 8'hE5;
      e_dlen = 4; e_dval = 32'h1234_5678;
      run("R8 R7 no-base", 0);

      // R8 mode 0, rm 5: absolute four-byte displacement, then imm8
      clear_exp(); push(8'h83); push(8'h3D); add_field(32'h8000_0010, 4); push(8'h80);
      e_op = 8'h83; e_form = 1; e_mrm = 8'h3D; e_dlen = 4; e_dval = 32'h8000_0010;
      e_ilen = 1; e_ival = 32'hFFFF_FF80;
      run("R8 absolute", 0);

      // R5 escaped opcode with full immediate
      clear_exp(); push(8'h0F); push(8'h84); add_field(32'hFFFF_FF00, 4);
      e_two = 1; e_op = 8'h84; e_ilen = 4; e_ival = 32'hFFFF_FF00;
      run("R5 escape", 0);

      // R5 unsupported one-byte and escaped opcodes
      clear_exp(); push(8'h06); e_inv = 1;
      run("R5 bad one-byte", 0);
      clear_exp(); push(8'h0F); push(8'h0B); e_inv = 1;
      run("R5 bad escaped", 0);

      // R3 one prefix more than allowed
      clear_exp(); push(8'hF0); push(8'hF2); push(8'h66); push(8'h2E); push(8'h3E); e_inv = 1;
      run("R3 overflow", 0);

      // R3 exactly MAX_PFX prefix/extension bytes still decode
      clear_exp(); push(8'hF3); push(8'h64); push(8'h67); push(8'h41); push(8'h90);
      e_flags = 6'b101100; e_exts = 1; e_ext = 4'h1; e_op = 8'h90;
      run("R3 at limit", 0);

      // R10 idle cycles with junk on the byte lane, then a one-byte instruction
      @(negedge clk); in_valid = 1'b0; in_byte = 8'h0F;
      @(negedge clk); in_byte = 8'hF0;
      @(negedge clk);
      check("R10", "idle no done", done, 0);
      clear_exp(); push(8'h53); e_op = 8'h53;
      run("R10 after idle", 0);

      for (int n = 0; n < 300; n++) begin
         gen_random();
         run("RND", 1'b1);
      end

      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      nchk++;
      nerr++;
      $display("FAIL R10 watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

endmodule